// File: doc/BRIEF.md
# Lane-Split Logical Shifter

This block shifts a 24-bit word left or right by a single scalar amount, without any clock. The word is divided into three 8-bit segments. Two gate inputs decide at run time whether the segment edges at bit 8 and bit 16 act as walls. Each group of segments joined by open edges forms one lane. Every lane shifts by itself, and no bit moves across a closed wall.

A single 5-bit shift amount drives all lanes. Each lane takes only as many low bits of that amount as its own width calls for: three bits for an 8-bit lane, four for a 16-bit lane and five for the full 24-bit lane. A datapath can therefore reuse one shifter for one wide operand, for a 16+8 or 8+16 split, or for three packed bytes, by changing the gates and nothing else.

Top module: `lane_split_shifter`

## Requirements
- R1: With gate_i = 2'b00 the whole word [23:0] is one lane and the shift uses amount_i[4:0].
- R2: With gate_i = 2'b01 (bit 0 closes the wall at bit 8) the lanes are [7:0] and [23:8]. The low lane uses amount_i[2:0] and the high lane uses amount_i[3:0].
- R3: With gate_i = 2'b10 (bit 1 closes the wall at bit 16) the lanes are [15:0] and [23:16]. The low lane uses amount_i[3:0] and the high lane uses amount_i[2:0].
- R4: With gate_i = 2'b11 there are three 8-bit lanes, [7:0], [15:8] and [23:16], and each uses amount_i[2:0].
- R5: With dir_right_i = 0 every lane shifts toward its top bit. Bits leaving the top of a lane are lost and zeros enter at the bottom of the lane.
- R6: With dir_right_i = 1 every lane shifts logically toward its bottom bit. Bits leaving the bottom of a lane are lost and zeros enter at the top of the lane.
- R7: Bits of amount_i above a lane's own field do not change that lane's result. An amount whose field is zero leaves the lane unchanged.
- R8: In the single 24-bit lane, a shift amount from 24 to 31 gives an all-zero result.
- R9: result_o depends only on the present inputs. It follows an input change within the same time step, with no clock or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 24 | Word to shift |
| amount_i | input | 5 | Shared shift amount |
| gate_i | input | 2 | Wall enables: bit 0 for the wall at bit 8, bit 1 for the wall at bit 16 |
| dir_right_i | input | 1 | 0 shifts left, 1 shifts right logically |
| result_o | output | 24 | Shifted word |

## Verification
The bound checker tests, at every input change, facts that hold for any data. A shift never adds set bits. A zero amount is the identity. Byte lanes with a non-zero field take a zero at the end that is filled. A full-width lane shifted by 24 or more is zero. Other facts depend on matching exact values. These are the wall positions for each gate setting, the masking of each lane's amount, and the lost bits. Only the bench shows them, by sweeping every amount in both directions under all four gate settings and comparing each result with a lane-by-lane arithmetic model.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // Direction encoding on the shifter's control input.
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;

  localparam int DEF_SEG_W   = 8;
  localparam int DEF_NUM_SEG = 3;
endpackage

// File: rtl/pss_lane_map.sv
// Turns the wall gates into, per segment, the bounds of its lane and the
// shift-amount field that lane may use.
module pss_lane_map #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 3,
  parameter int IDX_W   = 5,
  parameter int AMT_W   = 5
) (
  input  logic [NUM_SEG-2:0]             gate_i,
  output logic [NUM_SEG-1:0][IDX_W-1:0]  lo_bit_o,
  output logic [NUM_SEG-1:0][IDX_W-1:0]  hi_bit_o,
  output logic [NUM_SEG-1:0][AMT_W-1:0]  amt_mask_o
);

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    int lo_seg;
    int hi_seg;
    int lane_w;

    always_comb begin
      lo_seg = 0;
      for (int k = 1; k <= j; k++) begin
        if (gate_i[k-1]) lo_seg = k;
      end
      hi_seg = NUM_SEG - 1;
      for (int k = NUM_SEG - 1; k > j; k--) begin
        if (gate_i[k-1]) hi_seg = k - 1;
      end
      lane_w = (hi_seg - lo_seg + 1) * SEG_W;
      amt_mask_o[j] = '0;
      for (int b = 0; b < AMT_W; b++) begin
        if ((1 << b) < lane_w) amt_mask_o[j][b] = 1'b1;
      end
      lo_bit_o[j] = IDX_W'(lo_seg * SEG_W);
      hi_bit_o[j] = IDX_W'((hi_seg + 1) * SEG_W - 1);
    end
  end

endmodule

// File: rtl/pss_stage.sv
// One power-of-two step of the log shifter; moves bits only inside a lane.
module pss_stage
  import pss_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 3,
  parameter int IDX_W   = 5,
  parameter int SHIFT   = 1,
  localparam int DATA_W = SEG_W * NUM_SEG
) (
  input  logic [DATA_W-1:0]              data_i,
  input  shift_dir_e                     dir_i,
  input  logic [NUM_SEG-1:0]             seg_en_i,
  input  logic [NUM_SEG-1:0][IDX_W-1:0]  lo_bit_i,
  input  logic [NUM_SEG-1:0][IDX_W-1:0]  hi_bit_i,
  output logic [DATA_W-1:0]              data_o
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam int SEG = i / SEG_W;
    logic from_below;
    logic from_above;

    if (i >= SHIFT) begin : g_lo_src
      assign from_below = (lo_bit_i[SEG] <= IDX_W'(i - SHIFT)) & data_i[i-SHIFT];
    end else begin : g_lo_none
      assign from_below = 1'b0;
    end

    if (i + SHIFT < DATA_W) begin : g_hi_src
      assign from_above = (hi_bit_i[SEG] >= IDX_W'(i + SHIFT)) & data_i[i+SHIFT];
    end else begin : g_hi_none
      assign from_above = 1'b0;
    end

    assign data_o[i] = !seg_en_i[SEG] ? data_i[i]
                     : (dir_i == DIR_RIGHT) ? from_above : from_below;
  end

endmodule

// File: rtl/lane_split_shifter.sv
module lane_split_shifter
  import pss_pkg::*;
#(
  parameter int  SEG_W   = DEF_SEG_W,
  parameter int  NUM_SEG = DEF_NUM_SEG,
  localparam int DATA_W  = SEG_W * NUM_SEG,
  localparam int AMT_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [AMT_W-1:0]   amount_i,
  input  logic [NUM_SEG-2:0] gate_i,
  input  logic               dir_right_i,
  output logic [DATA_W-1:0]  result_o
);

  localparam int IDX_W = AMT_W;

  logic [NUM_SEG-1:0][IDX_W-1:0] lo_bit;
  logic [NUM_SEG-1:0][IDX_W-1:0] hi_bit;
  logic [NUM_SEG-1:0][AMT_W-1:0] amt_mask;
  logic [DATA_W-1:0]             chain [AMT_W+1];
  shift_dir_e                    dir;

  assign dir      = shift_dir_e'(dir_right_i);
  assign chain[0] = data_i;

  pss_lane_map #(
    .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .AMT_W(AMT_W)
  ) u_map (
    .gate_i    (gate_i),
    .lo_bit_o  (lo_bit),
    .hi_bit_o  (hi_bit),
    .amt_mask_o(amt_mask)
  );

  for (genvar k = 0; k < AMT_W; k++) begin : g_step
    logic [NUM_SEG-1:0] seg_en;
    for (genvar j = 0; j < NUM_SEG; j++) begin : g_en
      assign seg_en[j] = amount_i[k] & amt_mask[j][k];
    end

    pss_stage #(
      .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .SHIFT(1 << k)
    ) u_stage (
      .data_i  (chain[k]),
      .dir_i   (dir),
      .seg_en_i(seg_en),
      .lo_bit_i(lo_bit),
      .hi_bit_i(hi_bit),
      .data_o  (chain[k+1])
    );
  end

  assign result_o = chain[AMT_W];

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int  SEG_W   = 8,
  parameter int  NUM_SEG = 3,
  localparam int DATA_W  = SEG_W * NUM_SEG,
  localparam int AMT_W   = $clog2(DATA_W),
  localparam int SEG_AW  = $clog2(SEG_W)
) (
  input logic [DATA_W-1:0]  data_i,
  input logic [AMT_W-1:0]   amount_i,
  input logic [NUM_SEG-2:0] gate_i,
  input logic               dir_right_i,
  input logic [DATA_W-1:0]  result_o
);

  always_comb begin
    assert_bitloss_R5: assert ($countones(result_o) <= $countones(data_i));
    if (amount_i == '0) begin
      assert_identity_R7: assert (result_o == data_i);
    end
    if (gate_i == '0 && int'(amount_i) >= DATA_W) begin
      assert_wide_zero_R8: assert (result_o == '0);
    end
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_lane
    always_comb begin
      if ((&gate_i) && amount_i[SEG_AW-1:0] != '0 && !dir_right_i) begin
        assert_left_fill_R4: assert (result_o[j*SEG_W] == 1'b0);
      end
      if ((&gate_i) && amount_i[SEG_AW-1:0] != '0 && dir_right_i) begin
        assert_right_fill_R6: assert (result_o[j*SEG_W+SEG_W-1] == 1'b0);
      end
    end
  end

endmodule

bind lane_split_shifter pss_checker #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_chk (
  .data_i     (data_i),
  .amount_i   (amount_i),
  .gate_i     (gate_i),
  .dir_right_i(dir_right_i),
  .result_o   (result_o)
);

// File: tb/tb_lane_split_shifter.sv
`timescale 1ns/1ps
module tb_lane_split_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] data_i;
  logic [4:0]  amount_i;
  logic [1:0]  gate_i;
  logic        dir_right_i;
  logic [23:0] result_o;
  int          n_checks = 0;
  int          n_errors = 0;

  always #2 clk = ~clk;

  lane_split_shifter dut (
    .data_i(data_i), .amount_i(amount_i), .gate_i(gate_i),
    .dir_right_i(dir_right_i), .result_o(result_o)
  );

  function automatic longint lane_ref(longint d, int amt, int lo, int hi, bit right);
    int     w = hi - lo + 1;
    longint m = (longint'(1) << w) - 1;
    int     s = (w <= 8) ? (amt & 7) : (w <= 16) ? (amt & 15) : (amt & 31);
    longint v = (d >> lo) & m;
    v = right ? (v >> s) : ((v << s) & m);
    return v << lo;
  endfunction

  function automatic logic [23:0] model(logic [23:0] d, int amt, logic [1:0] g, bit right);
    longint r = 0;
    case (g)
      2'b00: r = lane_ref(d, amt, 0, 23, right);
      2'b01: r = lane_ref(d, amt, 0, 7, right) | lane_ref(d, amt, 8, 23, right);
      2'b10: r = lane_ref(d, amt, 0, 15, right) | lane_ref(d, amt, 16, 23, right);
      default: r = lane_ref(d, amt, 0, 7, right) | lane_ref(d, amt, 8, 15, right)
                 | lane_ref(d, amt, 16, 23, right);
    endcase
    return r[23:0];
  endfunction

  task automatic check(string req, logic [23:0] exp);
    n_checks++;
    if (result_o !== exp) begin
      n_errors++;
      $display("FAIL %s: gate=%b dir=%0b amt=%0d data=%h actual=%h expected=%h",
               req, gate_i, dir_right_i, amount_i, data_i, result_o, exp);
    end
  endtask

  task automatic run_all();
    logic [23:0] pats [8];
    string       req;
    pats[0] = 24'hFFFFFF; pats[1] = 24'h800001; pats[2] = 24'h818181;
    for (int p = 3; p < 8; p++) pats[p] = 24'($urandom);

    // R9: all-zero inputs give zero, and a change settles with no clock edge
    data_i = '0; amount_i = '0; gate_i = '0; dir_right_i = 1'b0;
    @(negedge clk); #1;
    check("R9 idle", 24'h0);
    data_i = 24'h000011; amount_i = 5'd4; #1;
    check("R9 comb", 24'h000110);

    for (int p = 0; p < 8; p++)
      for (int g = 0; g < 4; g++)
        for (int dr = 0; dr < 2; dr++)
          for (int a = 0; a < 32; a++) begin
            @(posedge clk); #1;
            data_i = pats[p]; gate_i = 2'(g); dir_right_i = dr[0]; amount_i = 5'(a);
            #1;
            req = (g == 0) ? "R1" : (g == 1) ? "R2" : (g == 2) ? "R3" : "R4";
            req = {req, dr ? " R6" : " R5"};
            if ((g == 3 && a >= 8) || (g != 0 && a >= 16)) req = {req, " R7"};
            if (g == 0 && a >= 24) req = {req, " R8"};
            check(req, model(pats[p], a, 2'(g), dr[0]));
          end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule